// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block collects up to fifteen interrupt request lines and presents them to a processor as one interrupt output. Inside, two eight-input fixed-priority units are chained: the secondary unit serves lines 8 to 15, and its "any request" output takes the place of input 2 of the primary unit, which serves lines 0 to 7. Line 2 is not usable as a direct request. Rising edges on the request lines are latched as pending. The block picks the winner by fixed priority, compares it with the highest line in service, and raises the interrupt output when the winner ranks higher.

The processor answers with a one-cycle acknowledge pulse. The block then marks the winner in service, clears its pending bit, and drives an eight-bit vector for one cycle. The vector is a programmed base plus the line number. Line 9 is an exception: it reports itself as line 2, so older handlers written for line 2 keep working. A four-entry write port sets the vector base, the two mask bytes, and the end-of-interrupt command that clears a line's in-service bit.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low, the vector base is 0, and all sixteen mask bits are set, so a request edge raises no interrupt.
- R2: A rising edge on `irq_in[n]` latches line n as pending. A pending, unmasked line raises `int_out` in the cycle after the edge, and it stays pending after `irq_in[n]` falls until it is acknowledged.
- R3: A set mask bit stops its line from raising `int_out`, but the request stays latched. Clearing the mask then raises `int_out` with no new edge. Register address 1 holds mask bits 7:0 and address 2 holds mask bits 15:8.
- R4: Priority is fixed, from highest to lowest: 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. The secondary group sits at the priority of primary input 2.
- R5: An `int_ack` pulse while `int_out` is high makes `vec_valid` high for one cycle on the next clock, with `vec_data` equal to base plus the winning line number. The base is written at register address 0. An `int_ack` while `int_out` is low does nothing.
- R6: Line 9 is delivered with `vec_data` equal to base plus 2.
- R7: An acknowledge sets the winner's in-service bit. While a line is in service, lines of equal or lower priority cannot raise `int_out`. A write to register address 3 clears the in-service bit of the line given in data bits 3:0.
- R8: A pending line whose priority is higher than every line in service raises `int_out`, which pre-empts the handler in service.
- R9: `irq_in[2]` has no effect, because input 2 of the primary unit is taken by the cascade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request lines; bit 2 is unused |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 mask low, 2 mask high, 3 end of interrupt |
| reg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe, high for one cycle |
| vec_data | output | 8 | Vector of the acknowledged line |

## Verification
Each result has a fixed number of cycles between its stimulus and its appearance:
- A request edge or a register write changes `int_out` one clock later, because only the pending, mask and in-service registers lie between them.
- An accepted acknowledge produces the vector on the clock that samples it, so the vector is due at the following falling edge.

The bench drives inputs on falling edges and samples exactly one falling edge after each stimulus. The acknowledge task pushes the expected vector into a queue. The monitor pops the queue on each vector strobe, so an unexpected or missing vector is reported.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int UNIT_IN  = 8;
  localparam int LINES    = 2 * UNIT_IN;
  localparam int LINE_W   = $clog2(LINES);
  localparam int IDX_W    = $clog2(UNIT_IN);
  localparam int CASC_IN  = 2;
  localparam int REMAP_SRC = UNIT_IN + 1;

  typedef logic [LINE_W-1:0] line_t;

  typedef enum logic [1:0] {
    REG_BASE   = 2'd0,
    REG_MASK_LO = 2'd1,
    REG_MASK_HI = 2'd2,
    REG_EOI    = 2'd3
  } reg_sel_e;

  // Lower rank means higher priority; the secondary group occupies input 2.
  function automatic line_t line_rank(input line_t l);
    if (l < CASC_IN)       return l;
    else if (l >= UNIT_IN) return line_t'(l - UNIT_IN + CASC_IN);
    else                   return line_t'(l + UNIT_IN - 1);
  endfunction
endpackage

// File: rtl/cirq_prio8.sv
module cirq_prio8 #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/cirq_resolve.sv
module cirq_resolve
  import cirq_pkg::*;
(
  input  logic [LINES-1:0] req,
  output logic             valid,
  output line_t            line
);
  logic             sec_any;
  logic [IDX_W-1:0] sec_idx;
  logic             pri_any;
  logic [IDX_W-1:0] pri_idx;
  logic [UNIT_IN-1:0] pri_req;

  always_comb begin
    pri_req          = req[UNIT_IN-1:0];
    pri_req[CASC_IN] = sec_any;
  end

  cirq_prio8 #(.N(UNIT_IN)) u_sec (
    .req (req[LINES-1:UNIT_IN]),
    .any (sec_any),
    .idx (sec_idx)
  );

  cirq_prio8 #(.N(UNIT_IN)) u_pri (
    .req (pri_req),
    .any (pri_any),
    .idx (pri_idx)
  );

  always_comb begin
    valid = pri_any;
    if (pri_idx == IDX_W'(CASC_IN)) line = {1'b1, sec_idx};
    else                            line = {1'b0, pri_idx};
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      irq_in,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             int_ack,
  output logic             int_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data
);
  localparam logic [LINES-1:0] USABLE = ~(LINES'(1) << CASC_IN);
  localparam line_t NO_RANK = '1;

  logic [LINES-1:0] irq_prev_q, pend_q, mask_q, isr_q;
  logic [LINES-1:0] pend_n, mask_n, isr_n;
  logic [VEC_W-1:0] base_q, base_n, vec_q, vec_n;
  logic             vec_valid_q;

  logic [LINES-1:0] eligible, ack_clr, eoi_clr;
  logic             req_v, isr_v, ack_take;
  line_t            req_line, isr_line, isr_rank, vec_line;

  assign eligible = pend_q & ~mask_q & USABLE;

  cirq_resolve u_req (.req(eligible), .valid(req_v), .line(req_line));
  cirq_resolve u_isr (.req(isr_q),    .valid(isr_v), .line(isr_line));

  always_comb begin
    isr_rank = isr_v ? line_rank(isr_line) : NO_RANK;
    int_out  = req_v && (line_rank(req_line) < isr_rank);
    ack_take = int_ack && int_out;
    ack_clr  = ack_take ? (LINES'(1) << req_line) : '0;
    eoi_clr  = (reg_we && reg_sel_e'(reg_addr) == REG_EOI)
               ? (LINES'(1) << reg_wdata[LINE_W-1:0]) : '0;
    vec_line = (req_line == line_t'(REMAP_SRC)) ? line_t'(CASC_IN) : req_line;
  end

  always_comb begin
    pend_n = (pend_q & ~ack_clr) | (irq_in & ~irq_prev_q & USABLE);
    isr_n  = (isr_q & ~eoi_clr) | ack_clr;
    mask_n = mask_q;
    base_n = base_q;
    if (reg_we) begin
      case (reg_sel_e'(reg_addr))
        REG_BASE:    base_n = reg_wdata[VEC_W-1:0];
        REG_MASK_LO: mask_n[UNIT_IN-1:0] = reg_wdata[UNIT_IN-1:0];
        REG_MASK_HI: mask_n[LINES-1:UNIT_IN] = reg_wdata[UNIT_IN-1:0];
        default: ;
      endcase
    end
    vec_n = base_q + VEC_W'(vec_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q  <= '0;
      pend_q      <= '0;
      mask_q      <= '1;
      isr_q       <= '0;
      base_q      <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      irq_prev_q  <= irq_in;
      pend_q      <= pend_n;
      mask_q      <= mask_n;
      isr_q       <= isr_n;
      base_q      <= base_n;
      vec_valid_q <= ack_take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vec_q <= '0;
    else if (ack_take) vec_q <= vec_n;
  end

  assign vec_valid = vec_valid_q;
  assign vec_data  = vec_q;
endmodule

// File: rtl/cirq_chk.sv
module cirq_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_ack,
  input logic             int_out,
  input logic             vec_valid,
  input logic [VEC_W-1:0] vec_data,
  input logic [VEC_W-1:0] base_q,
  input logic [15:0]      mask_q,
  input logic [15:0]      isr_q,
  input logic             reg_we,
  input logic [1:0]       reg_addr
);
  logic eoi_we;
  assign eoi_we = reg_we && (reg_addr == 2'd3);

  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out) |=> vec_valid); // R5

  AST_NO_STRAY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack && int_out)); // R5

  AST_REMAP_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (VEC_W'(vec_data - $past(base_q)) != VEC_W'(9))); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 16'hFFFF) |-> !int_out); // R3

  AST_ISR_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !eoi_we) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R7
endmodule

bind cascade_irq_ctrl cirq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .int_ack   (int_ack),
  .int_out   (int_out),
  .vec_valid (vec_valid),
  .vec_data  (vec_data),
  .base_q    (base_q),
  .mask_q    (mask_q),
  .isr_q     (isr_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr)
);

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        int_ack = 1'b0;
  logic        int_out, vec_valid;
  logic [7:0]  vec_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_ack(int_ack),
    .int_out(int_out), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk);
    irq_in = bits;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic ack(input logic [7:0] exp_vec);
    @(negedge clk);
    int_ack = 1'b1;
    exp_q.push_back(exp_vec);
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic chk_int(input bit exp, input string tag);
    check(int_out == exp, tag, int_out, exp);
  endtask

  // Monitor: each vector strobe must match the oldest expected vector.
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected vector", vec_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(vec_data == e, "R5 vector value", vec_data, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int(1'b0, "R1 int_out after reset");
    check(vec_valid == 1'b0, "R1 vec_valid after reset", vec_valid, 0);
    pulse(16'h0020);
    chk_int(1'b0, "R1 reset masks block line 5");

    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    chk_int(1'b1, "R3 latched line 5 seen after unmask");
    ack(8'h25);
    wr(2'd3, 8'd5);
    chk_int(1'b0, "R7 idle after EOI");

    pulse(16'h0020);
    chk_int(1'b1, "R2 edge raises int_out");
    repeat (2) @(negedge clk);
    chk_int(1'b1, "R2 pending held after line drops");
    ack(8'h25);

    pulse(16'h0040);
    chk_int(1'b0, "R7 line 6 blocked by line 5 in service");
    pulse(16'h0008);
    chk_int(1'b1, "R8 line 3 pre-empts line 5");
    ack(8'h23);
    wr(2'd3, 8'd3);
    chk_int(1'b0, "R7 line 6 still blocked by line 5");
    wr(2'd3, 8'd5);
    chk_int(1'b1, "R7 line 6 released by EOI");
    ack(8'h26);
    wr(2'd3, 8'd6);

    pulse(16'h1010);
    ack(8'h2C);
    chk_int(1'b0, "R4 line 4 below cascade line 12");
    wr(2'd3, 8'd12);
    ack(8'h24);
    wr(2'd3, 8'd4);

    pulse(16'h0200);
    ack(8'h22);
    wr(2'd3, 8'd9);

    pulse(16'h0102);
    ack(8'h21);
    chk_int(1'b0, "R4 line 8 below line 1");
    wr(2'd3, 8'd1);
    ack(8'h28);
    wr(2'd3, 8'd8);

    pulse(16'h0004);
    chk_int(1'b0, "R9 line 2 ignored");

    wr(2'd1, 8'h80);
    pulse(16'h0080);
    chk_int(1'b0, "R3 masked line 7 quiet");
    wr(2'd1, 8'h00);
    chk_int(1'b1, "R3 line 7 kept latched");
    ack(8'h27);
    wr(2'd3, 8'd7);

    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    check(vec_valid == 1'b0, "R5 ack ignored with int_out low", vec_valid, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all vectors delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule